// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block tracks the producer and consumer positions of four circular descriptor rings that a DMA engine shares with software. Two rings carry receive traffic: a free-buffer ring that software fills and hardware drains, and a completion ring that hardware fills and software drains. Two rings carry transmit traffic: a send ring that software fills and hardware drains, and a reclaim ring that hardware fills and software drains. For each ring the block holds a base address, a descriptor count, a write index and a read index. Software reaches all of them through a flat register window. Pointers read back as byte offsets, where each descriptor occupies 32 bytes.

The hardware side moves the pointer it owns with a one-cycle strobe per ring. A direction gate register lets software allow or block each strobe. Each ring reports empty and full. A strobe that would underflow or overflow a ring is dropped and latches a sticky error bit. Base address and depth can change only while software holds the matching bit of that ring's guard word set. A change of depth restarts both indices of that ring at zero.

Top module: `ring_ptr_mgr`

## Requirements
- R1: Register groups sit at byte addresses 0x500 (receive free ring, ring 0), 0x520 (receive completion ring, ring 1), 0x580 (transmit send ring, ring 2) and 0x5A0 (transmit reclaim ring, ring 3). Within a group the offsets are: base +0x0, depth +0x4, write index +0x8, read index +0xC, guard +0x18. The direction gate is at 0x5CC. Any other address reads as zero and ignores writes.
- R2: The guard word stores bit 2 (base permit) and bit 1 (depth permit) and reads back with only those bits. A base write takes effect only while the ring's bit 2 is set. Otherwise the base is unchanged.
- R3: Depth is written and read as the descriptor count shifted left by 3. A depth write takes effect only while the ring's guard bit 1 is set and the count is between 2 and MAX_DESC. Otherwise it leaves the depth unchanged.
- R4: An accepted depth write sets both indices of that ring to zero.
- R5: Index registers read as the index shifted left by 5. Software may write only the index it owns: the write index of rings 0 and 2, and the read index of rings 1 and 3. The write is accepted only if the index (written data shifted right by 5) is below the depth. Writes to the hardware-owned index are ignored.
- R6: While its gate bit is set, a strobe on hw_step[r] advances the hardware-owned index of ring r by one and wraps from depth-1 to 0. The gate bits are: bit 2 for ring 0 reads, bit 3 for ring 1 writes, bit 0 for ring 2 reads, bit 1 for ring 3 writes. With the gate bit clear, the strobe has no effect.
- R7: ring_empty[r] is high when the write index equals the read index. ring_full[r] is high when advancing the write index by one (with wrap) would make it equal the read index.
- R8: A gated strobe on an empty ring 0 or 2, or on a full ring 1 or 3, leaves the indices unchanged and sets ring_err[r]. The bit stays set until reset.
- R9: After reset, every base is 0, every depth reads MAX_DESC<<3, all indices, guards, gate bits and error bits are 0, and every ring is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | AW | Register write byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | AW | Register read byte address |
| cfg_rdata | output | 32 | Read data for cfg_raddr, combinational |
| hw_step | input | 4 | Per-ring hardware advance strobe |
| ring_empty | output | 4 | Per-ring empty flag |
| ring_full | output | 4 | Per-ring full flag |
| ring_err | output | 4 | Per-ring sticky underflow/overflow flag |

## Verification
A register write or hardware strobe in a given cycle is seen at the first rising edge. Its effect on read data, ring_empty, ring_full and ring_err is visible right after that edge, because the flags and cfg_rdata are combinational from the registers. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass, and compares the flags and one read address on the next falling edge. The bench model is updated at that same rising edge. Same-cycle collisions follow fixed rules: a strobe is judged on the pre-edge indices, and an accepted depth write overrides any index movement in the same cycle.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int NRING       = 4;
  localparam int DESC_SHIFT  = 5;
  localparam int DEPTH_SHIFT = 3;
  localparam logic [11:0] GATE_ADDR = 12'h5CC;

  typedef enum logic [2:0] {
    FLD_NONE, FLD_BASE, FLD_DEPTH, FLD_WIDX, FLD_RIDX, FLD_GUARD
  } fld_e;

  function automatic logic [11:0] grp_addr(int r);
    case (r)
      0: return 12'h500;
      1: return 12'h520;
      2: return 12'h580;
      default: return 12'h5A0;
    endcase
  endfunction

  // bit of the gate register that enables the hardware strobe of ring r
  function automatic int gate_pos(int r);
    case (r)
      0: return 2;
      1: return 3;
      2: return 0;
      default: return 1;
    endcase
  endfunction

  // hardware produces (moves the write index) on rings 1 and 3
  function automatic bit hw_produces(int r);
    return (r == 1) || (r == 3);
  endfunction
endpackage

// File: rtl/ring_regdec.sv
module ring_regdec
  import ring_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0]    addr,
  output logic [NRING-1:0] ring_hit,
  output fld_e             fld,
  output logic             gate_hit
);
  always_comb begin
    ring_hit = '0;
    for (int r = 0; r < NRING; r++) begin
      ring_hit[r] = ({addr[AW-1:5], 5'b0} == AW'(grp_addr(r)));
    end
    gate_hit = (addr == AW'(GATE_ADDR));
    case (addr[4:0])
      5'h00:   fld = FLD_BASE;
      5'h04:   fld = FLD_DEPTH;
      5'h08:   fld = FLD_WIDX;
      5'h0C:   fld = FLD_RIDX;
      5'h18:   fld = FLD_GUARD;
      default: fld = FLD_NONE;
    endcase
  end
endmodule

// File: rtl/ring_slot.sv
module ring_slot
  import ring_pkg::*;
#(
  parameter int MAX_DESC = 64,
  parameter bit PRODUCER = 1'b0,
  localparam int PW = $clog2(MAX_DESC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_base,
  input  logic          we_depth,
  input  logic          we_widx,
  input  logic          we_ridx,
  input  logic          we_guard,
  input  logic [31:0]   wdata,
  input  logic          step,
  input  logic          gate_on,
  output logic [31:0]   base_o,
  output logic [PW-1:0] cnt_o,
  output logic [PW-1:0] widx_o,
  output logic [PW-1:0] ridx_o,
  output logic [1:0]    guard_o,
  output logic          empty,
  output logic          full,
  output logic          err
);
  logic [31:0] cnt_req, idx_req;
  logic        cnt_ok, idx_ok;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p, logic [PW-1:0] n);
    return (p == n - 1'b1) ? '0 : p + 1'b1;
  endfunction

  assign cnt_req = wdata >> DEPTH_SHIFT;
  assign idx_req = wdata >> DESC_SHIFT;
  assign cnt_ok  = (cnt_req >= 32'd2) && (cnt_req <= 32'(MAX_DESC));
  assign idx_ok  = (idx_req < 32'(cnt_o));
  assign empty   = (widx_o == ridx_o);
  assign full    = (bump(widx_o, cnt_o) == ridx_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o  <= '0;
      cnt_o   <= PW'(MAX_DESC);
      widx_o  <= '0;
      ridx_o  <= '0;
      guard_o <= '0;
      err     <= 1'b0;
    end else begin
      if (we_guard) guard_o <= wdata[2:1];
      if (we_base && guard_o[1]) base_o <= wdata;
      if (PRODUCER) begin
        if (step && gate_on) begin
          if (full) err <= 1'b1;
          else      widx_o <= bump(widx_o, cnt_o);
        end
        if (we_ridx && idx_ok) ridx_o <= idx_req[PW-1:0];
      end else begin
        if (step && gate_on) begin
          if (empty) err <= 1'b1;
          else       ridx_o <= bump(ridx_o, cnt_o);
        end
        if (we_widx && idx_ok) widx_o <= idx_req[PW-1:0];
      end
      if (we_depth && guard_o[0] && cnt_ok) begin
        cnt_o  <= cnt_req[PW-1:0];
        widx_o <= '0;
        ridx_o <= '0;
      end
    end
  end
endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
  import ring_pkg::*;
#(
  parameter int AW       = 12,
  parameter int MAX_DESC = 64,
  localparam int PW = $clog2(MAX_DESC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_waddr,
  input  logic [31:0]      cfg_wdata,
  input  logic [AW-1:0]    cfg_raddr,
  output logic [31:0]      cfg_rdata,
  input  logic [NRING-1:0] hw_step,
  output logic [NRING-1:0] ring_empty,
  output logic [NRING-1:0] ring_full,
  output logic [NRING-1:0] ring_err
);
  logic [NRING-1:0] w_hit, r_hit;
  fld_e             w_fld, r_fld;
  logic             w_gate, r_gate;
  logic [3:0]       gate_q;

  logic [31:0]   base_v  [NRING];
  logic [PW-1:0] cnt_v   [NRING];
  logic [PW-1:0] widx_v  [NRING];
  logic [PW-1:0] ridx_v  [NRING];
  logic [1:0]    guard_v [NRING];

  ring_regdec #(.AW(AW)) u_wdec (.addr(cfg_waddr), .ring_hit(w_hit), .fld(w_fld), .gate_hit(w_gate));
  ring_regdec #(.AW(AW)) u_rdec (.addr(cfg_raddr), .ring_hit(r_hit), .fld(r_fld), .gate_hit(r_gate));

  always_ff @(posedge clk) begin
    if (!rst_n)                gate_q <= '0;
    else if (cfg_we && w_gate) gate_q <= cfg_wdata[3:0];
  end

  for (genvar r = 0; r < NRING; r++) begin : g_ring
    logic sel;
    assign sel = cfg_we && w_hit[r];
    ring_slot #(.MAX_DESC(MAX_DESC), .PRODUCER(hw_produces(r))) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_base (sel && (w_fld == FLD_BASE)),
      .we_depth(sel && (w_fld == FLD_DEPTH)),
      .we_widx (sel && (w_fld == FLD_WIDX)),
      .we_ridx (sel && (w_fld == FLD_RIDX)),
      .we_guard(sel && (w_fld == FLD_GUARD)),
      .wdata   (cfg_wdata),
      .step    (hw_step[r]),
      .gate_on (gate_q[gate_pos(r)]),
      .base_o  (base_v[r]),
      .cnt_o   (cnt_v[r]),
      .widx_o  (widx_v[r]),
      .ridx_o  (ridx_v[r]),
      .guard_o (guard_v[r]),
      .empty   (ring_empty[r]),
      .full    (ring_full[r]),
      .err     (ring_err[r])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    if (r_gate) cfg_rdata = {28'b0, gate_q};
    for (int r = 0; r < NRING; r++) begin
      if (r_hit[r]) begin
        case (r_fld)
          FLD_BASE:  cfg_rdata = base_v[r];
          FLD_DEPTH: cfg_rdata = 32'(cnt_v[r]) << DEPTH_SHIFT;
          FLD_WIDX:  cfg_rdata = 32'(widx_v[r]) << DESC_SHIFT;
          FLD_RIDX:  cfg_rdata = 32'(ridx_v[r]) << DESC_SHIFT;
          FLD_GUARD: cfg_rdata = {29'b0, guard_v[r], 1'b0};
          default:   cfg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ring_ptr_chk.sv
module ring_ptr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] hw_step,
  input logic [3:0] gate_q,
  input logic [3:0] ring_empty,
  input logic [3:0] ring_full,
  input logic [3:0] ring_err
);
  logic [3:0] live;
  assign live = hw_step & {gate_q[1], gate_q[0], gate_q[3], gate_q[2]};

  // R7: with at least two descriptors a ring is never empty and full together
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_empty & ring_full) == 4'b0);

  // R8: error bits never clear while out of reset
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ring_err & $past(ring_err)) == $past(ring_err)));

  // R8: underflow on consumer rings
  a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (live[0] && ring_empty[0]) || (live[2] && ring_empty[2])
      |=> (ring_err[0] || !$past(live[0] && ring_empty[0])) &&
          (ring_err[2] || !$past(live[2] && ring_empty[2])));

  // R8: overflow on producer rings
  a_r8_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (live[1] && ring_full[1]) || (live[3] && ring_full[3])
      |=> (ring_err[1] || !$past(live[1] && ring_full[1])) &&
          (ring_err[3] || !$past(live[3] && ring_full[3])));

  // R6: without an enabled strobe no error can appear
  a_r6_gate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 4'b0) |=> $stable(ring_err));
endmodule

bind ring_ptr_mgr ring_ptr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_step(hw_step), .gate_q(gate_q),
  .ring_empty(ring_empty), .ring_full(ring_full), .ring_err(ring_err)
);

// File: tb/ring_ptr_mgr_bench.sv
`timescale 1ns/1ps
module ring_ptr_mgr_bench;
  localparam int MAXD = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [11:0] cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  hw_step = '0;
  logic [3:0]  ring_empty, ring_full, ring_err;

  int total = 0;
  int bad = 0;

  int unsigned m_base [4];
  int          m_cnt  [4];
  int          m_wi   [4];
  int          m_ri   [4];
  int          m_grd  [4];
  int          m_gate;
  bit          m_err  [4];

  always #4 clk = ~clk;

  ring_ptr_mgr u_ring_ptr_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .hw_step(hw_step), .ring_empty(ring_empty), .ring_full(ring_full),
    .ring_err(ring_err)
  );

  function automatic int grp(int r);
    case (r) 0: return 'h500; 1: return 'h520; 2: return 'h580; default: return 'h5A0; endcase
  endfunction
  function automatic int gbit(int r);
    case (r) 0: return 2; 1: return 3; 2: return 0; default: return 1; endcase
  endfunction
  function automatic int nxt(int p, int n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction
  function automatic bit is_prod(int r);
    return (r == 1) || (r == 3);
  endfunction

  function automatic logic [31:0] exp_read(int a);
    if (a == 'h5CC) return 32'(m_gate);
    for (int r = 0; r < 4; r++) begin
      if (a == grp(r))        return m_base[r];
      if (a == grp(r) + 'h4)  return 32'(m_cnt[r] << 3);
      if (a == grp(r) + 'h8)  return 32'(m_wi[r] << 5);
      if (a == grp(r) + 'hC)  return 32'(m_ri[r] << 5);
      if (a == grp(r) + 'h18) return 32'(m_grd[r] << 1);
    end
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < 4; r++) begin
      m_base[r] = 0; m_cnt[r] = MAXD; m_wi[r] = 0; m_ri[r] = 0; m_grd[r] = 0; m_err[r] = 0;
    end
    m_gate = 0;
  endtask

  task automatic model_step(bit we, int a, logic [31:0] d, logic [3:0] st);
    for (int r = 0; r < 4; r++) begin
      bit emp, ful;
      int v, ix;
      emp = (m_wi[r] == m_ri[r]);
      ful = (nxt(m_wi[r], m_cnt[r]) == m_ri[r]);
      if (st[r] && m_gate[gbit(r)]) begin
        if (is_prod(r)) begin
          if (ful) m_err[r] = 1; else m_wi[r] = nxt(m_wi[r], m_cnt[r]);
        end else begin
          if (emp) m_err[r] = 1; else m_ri[r] = nxt(m_ri[r], m_cnt[r]);
        end
      end
      ix = int'(d >> 5);
      v  = int'(d >> 3);
      if (we) begin
        if (a == grp(r) && m_grd[r][1]) m_base[r] = d;
        if (a == grp(r) + 'h18) m_grd[r] = int'(d[2:1]);
        if (a == grp(r) + 'h8 && !is_prod(r) && ix < m_cnt[r]) m_wi[r] = ix;
        if (a == grp(r) + 'hC &&  is_prod(r) && ix < m_cnt[r]) m_ri[r] = ix;
        if (a == grp(r) + 'h4 && m_grd[r][0] && v >= 2 && v <= MAXD) begin
          m_cnt[r] = v; m_wi[r] = 0; m_ri[r] = 0;
        end
      end
    end
    if (we && a == 'h5CC) m_gate = int'(d[3:0]);
  endtask

  task automatic check_flags();
    logic [3:0] e, f, x;
    for (int r = 0; r < 4; r++) begin
      e[r] = (m_wi[r] == m_ri[r]);
      f[r] = (nxt(m_wi[r], m_cnt[r]) == m_ri[r]);
      x[r] = m_err[r];
    end
    chk("R7 empty", 32'(ring_empty), 32'(e));
    chk("R7 full", 32'(ring_full), 32'(f));
    chk("R8 err", 32'(ring_err), 32'(x));
  endtask

  task automatic rd(string tag, int a);
    cfg_raddr = 12'(a);
    #1;
    chk(tag, cfg_rdata, exp_read(a));
  endtask

  task automatic cyc(bit we, int a, logic [31:0] d, logic [3:0] st);
    cfg_we = we; cfg_waddr = 12'(a); cfg_wdata = d; hw_step = st;
    @(posedge clk);
    model_step(we, a, d, st);
    @(negedge clk);
    cfg_we = 0; hw_step = 0;
    check_flags();
  endtask

  task automatic rd_ring(string tag, int r);
    rd(tag, grp(r)); rd(tag, grp(r) + 4); rd(tag, grp(r) + 8);
    rd(tag, grp(r) + 'hC); rd(tag, grp(r) + 'h18);
  endtask

  initial begin
    #(8.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check_flags();
    chk("R9 depth reset", 32'(0), 32'(0));
    rd("R9 depth0", 'h504);
    chk("R9 depth literal", cfg_rdata, 32'h200);
    for (int r = 0; r < 4; r++) rd_ring("R9 ring", r);
    rd("R9 gate", 'h5CC);

    // R2 base guard
    cyc(1, 'h580, 32'hDEAD_0000, 0);
    rd("R2 base blocked", 'h580);
    chk("R2 base literal", cfg_rdata, 32'h0);
    for (int r = 0; r < 4; r++) begin
      cyc(1, grp(r) + 'h18, 32'h4, 0);
      cyc(1, grp(r), 32'h1000_0000 + 32'(r), 0);
      cyc(1, grp(r) + 'h18, 32'h0, 0);
      rd("R1 R2 base", grp(r));
      rd("R2 guard", grp(r) + 'h18);
    end
    // R1 unmapped
    cyc(1, 'h510, 32'hFFFF_FFFF, 0);
    rd("R1 unmapped", 'h510);
    rd("R1 unmapped2", 'h5C8);

    // R3 depth guard and range; R4 clears
    cyc(1, 'h504, 32'(4 << 3), 0);
    rd("R3 depth blocked", 'h504);
    for (int r = 0; r < 4; r++) cyc(1, grp(r) + 'h18, 32'h2, 0);
    cyc(1, 'h504, 32'(1 << 3), 0);
    rd("R3 depth 1 rejected", 'h504);
    cyc(1, 'h504, 32'(65 << 3), 0);
    rd("R3 depth 65 rejected", 'h504);
    cyc(1, 'h508, 32'(3 << 5), 0);
    cyc(1, 'h504, 32'(4 << 3), 0);
    rd("R4 widx cleared", 'h508);
    rd("R3 depth 4", 'h504);
    chk("R3 depth literal", cfg_rdata, 32'h20);
    for (int r = 1; r < 4; r++) cyc(1, grp(r) + 4, 32'(3 << 3), 0);

    // R5 ownership and range
    cyc(1, 'h50C, 32'(2 << 5), 0);
    rd("R5 hw-owned ignored", 'h50C);
    cyc(1, 'h508, 32'(4 << 5), 0);
    rd("R5 out of range", 'h508);
    cyc(1, 'h508, 32'(3 << 5), 0);
    rd("R5 sw widx", 'h508);
    chk("R5 widx literal", cfg_rdata, 32'h60);

    // R6 gate off: no movement
    cyc(0, 0, 0, 4'hF);
    rd("R6 gate off", 'h50C);
    cyc(1, 'h5CC, 32'hF, 0);
    // R6 wrap on ring 0 depth 4: rp 0->1->2->3 then empty
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 4'b0001);
    rd("R6 advance", 'h50C);
    cyc(0, 0, 0, 4'b0001);
    rd("R8 underflow", 'h50C);
    cyc(1, 'h508, 32'(1 << 5), 0);
    cyc(0, 0, 0, 4'b0001);
    rd("R6 wrap", 'h50C);
    chk("R6 wrap literal", cfg_rdata, 32'h0);
    // R8 overflow on ring 1 depth 3
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 4'b0010);
    rd("R8 overflow", 'h528);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      int r, sel, a;
      logic [31:0] d;
      logic [3:0] st;
      bit we;
      r = int'($urandom_range(0, 3));
      sel = int'($urandom_range(0, 9));
      we = ($urandom_range(0, 2) != 0);
      d = $urandom;
      case (sel)
        0: a = grp(r);
        1: begin a = grp(r) + 4; d = 32'($urandom_range(0, 70) << 3); end
        2, 3: begin a = grp(r) + 8; d = 32'($urandom_range(0, 9) << 5); end
        4, 5: begin a = grp(r) + 'hC; d = 32'($urandom_range(0, 9) << 5); end
        6: a = grp(r) + 'h18;
        7: a = 'h5CC;
        8: a = grp(r) + 'h10;
        default: a = int'($urandom_range(0, 4095)) & 'hFFC;
      endcase
      st = 4'($urandom);
      cyc(we, a, d, st);
      rd("R1 R5 random read", (i % 2 == 0) ? a : grp(r) + 8 + 4 * (i % 3 == 0));
      if (i % 1500 == 1499) begin
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
        check_flags();
        rd_ring("R9 re-reset", r);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule